// File: doc/BRIEF.md
# Machine Cycle Timing Generator

This block divides the oscillator clock into the internal timing frame of a classic 8-bit controller core. Each state spans two oscillator periods (a first and a second phase), and six states S1 to S6 make one machine cycle of 12 oscillator periods. The block reports the current phase and state. It gives a one-clock strobe on the last period of every machine cycle and drives an address-latch-enable output that pulses twice per machine cycle while the core runs. It also keeps a 2-bit index of the machine cycle within an instruction, which wraps after one, two or four cycles.

An active-high reset pin enters through a synchronizer. A qualifier turns it into a synchronous core reset only once the synchronized level has stayed high for two whole machine cycles. A shorter pulse is discarded and its partial count is cleared. While the core reset is active the sequence is parked at S1 first phase. It starts moving on the first oscillator edge after the core reset drops. A separate active-low asynchronous input `rst_ni` clears every register at power-up.

Top module: `mc_timing_gen`

## Requirements
- R1: While `rst_ni` is low, all outputs are zero: `core_rst_o`, `phase_o`, `state_o`, `ale_o`, `cycle_end_o` and `mcycle_idx_o`.
- R2: Out of reset, `phase_o` (0 = first phase, 1 = second phase) alternates on every clock. `state_o` (0 = S1 … 5 = S6) advances after each second phase. S6 second phase is followed by S1 first phase, so one machine cycle lasts 12 clocks.
- R3: `ale_o` is high exactly in S1 second phase, S2 first phase, S4 second phase and S5 first phase. That gives two 2-clock pulses per machine cycle.
- R4: `cycle_end_o` is high for exactly one clock in each machine cycle, in S6 second phase.
- R5: `rst_pin_i` passes through a two-flop synchronizer. `core_rst_o` rises once the synchronized level has been high on 24 consecutive clock edges. With the pin raised before clock edge 0, `core_rst_o` is still low after edge 24 and high after edge 25.
- R6: If the synchronized pin goes low before qualification, the count is cleared and `core_rst_o` stays low. A later high stretch must again last the full 24 clocks.
- R7: While `core_rst_o` is high, the sequence holds at S1 first phase, with `ale_o`, `cycle_end_o` and `mcycle_idx_o` at 0.
- R8: With the pin lowered before edge 0, `core_rst_o` is still high after edge 1 and low after edge 2. Edge 3 moves the sequence to S1 second phase.
- R9: `mcycle_idx_o` starts at 0 after the core reset and advances on the edge that leaves S6 second phase. It wraps to 0 after the last cycle, as set by `inst_len_i` sampled on that edge: 2'b00 one cycle, 2'b01 two cycles, 2'b10 or 2'b11 four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous power-up clear, active low |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| inst_len_i | input | 2 | Machine cycles in the current instruction |
| core_rst_o | output | 1 | Qualified synchronous core reset |
| phase_o | output | 1 | Phase within state, 0 first, 1 second |
| state_o | output | 3 | State number, 0 = S1 to 5 = S6 |
| ale_o | output | 1 | Address latch enable, two pulses per machine cycle |
| cycle_end_o | output | 1 | One-clock strobe in S6 second phase |
| mcycle_idx_o | output | 2 | Machine cycle index within the instruction |

## Verification
A slipped phase or state register moves the `ale_o` pulses and the `cycle_end_o` strobe off their positions. This shows within one 12-clock machine cycle of the fault, and the bench compares all outputs against a position model on every clock. A qualifier count off by one moves the rise of `core_rst_o` by a single clock. A missing counter clear lets two short pin pulses add up into a false reset, which shows after the second pulse. A wrong wrap of the cycle index shows on the first machine cycle boundary past the programmed length.

// File: rtl/mc_timing_pkg.sv
package mc_timing_pkg;
  typedef enum logic [1:0] {
    LEN_ONE   = 2'b00,
    LEN_TWO   = 2'b01,
    LEN_FOUR  = 2'b10,
    LEN_FOURX = 2'b11
  } inst_len_e;

  // latch pulses start in the second phase of these states (S1, S4)
  localparam int unsigned ALE_FIRST  = 0;
  localparam int unsigned ALE_SECOND = 3;
endpackage

// File: rtl/mc_rst_qual.sv
module mc_rst_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CLKS   = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic core_rst_o
);
  localparam int unsigned CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_CLKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   core_q;
  logic                   pin_sync;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= pin_i;

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
  end

  assign pin_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      core_q <= 1'b0;
    end else if (!pin_sync) begin
      cnt_q  <= '0;
      core_q <= 1'b0;
    end else if (!core_q) begin
      if (cnt_q == CNT_LAST) core_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign core_rst_o = core_q;

  a_r5_qual_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_q) |-> ($past(cnt_q) == CNT_LAST && $past(pin_sync)));
  a_r6_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_sync |=> (cnt_q == '0 && !core_q));
endmodule

// File: rtl/mc_phase_seq.sv
module mc_phase_seq
  import mc_timing_pkg::*;
#(
  parameter int unsigned STATES = 6,
  parameter int unsigned SW     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  output logic          phase_o,
  output logic [SW-1:0] state_o,
  output logic          ale_o,
  output logic          cyc_end_o
);
  localparam logic [SW-1:0] LAST = SW'(STATES - 1);
  localparam logic [SW-1:0] A0   = SW'(ALE_FIRST);
  localparam logic [SW-1:0] A1   = SW'(ALE_SECOND);

  logic          phase_q, phase_d;
  logic [SW-1:0] state_q, state_d;
  logic          ale_q, ale_d, end_q, end_d;

  always_comb begin
    if (hold_i) begin
      phase_d = 1'b0;
      state_d = '0;
    end else if (!phase_q) begin
      phase_d = 1'b1;
      state_d = state_q;
    end else begin
      phase_d = 1'b0;
      state_d = (state_q == LAST) ? '0 : state_q + 1'b1;
    end
    // registered decode of the next position keeps outputs glitch free
    ale_d = (phase_d  && (state_d == A0 || state_d == A1)) ||
            (!phase_d && (state_d == A0 + 1'b1 || state_d == A1 + 1'b1));
    end_d = phase_d && (state_d == LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      state_q <= '0;
      ale_q   <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      state_q <= state_d;
      ale_q   <= ale_d;
      end_q   <= end_d;
    end
  end

  assign phase_o   = phase_q;
  assign state_o   = state_q;
  assign ale_o     = ale_q;
  assign cyc_end_o = end_q;

  a_r2_phase_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i) |=> (phase_q != $past(phase_q)));
  a_r2_state_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && phase_q && state_q == LAST) |=> (state_q == '0 && !phase_q));
  a_r2_state_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !phase_q) |=> $stable(state_q));
  a_r7_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (state_q == '0 && !phase_q && !ale_q && !end_q));
  a_r2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q <= LAST);
endmodule

// File: rtl/mc_cycle_idx.sv
module mc_cycle_idx
  import mc_timing_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             cyc_end_i,
  input  inst_len_e        len_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, last;

  always_comb begin
    unique case (len_i)
      LEN_ONE: last = '0;
      LEN_TWO: last = IDX_W'(1);
      default: last = IDX_W'(3);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (hold_i)    idx_q <= '0;
    else if (cyc_end_i) idx_q <= (idx_q == last) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  a_r9_idx_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !cyc_end_i) |=> $stable(idx_q));
  a_r9_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && cyc_end_i && len_i == LEN_ONE) |=> idx_q == '0);
endmodule

// File: rtl/mc_timing_gen.sv
module mc_timing_gen
  import mc_timing_pkg::*;
#(
  parameter int unsigned STATES      = 6,
  parameter int unsigned QUAL_MCYC   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rst_pin_i,
  input  logic [1:0]                 inst_len_i,
  output logic                       core_rst_o,
  output logic                       phase_o,
  output logic [$clog2(STATES)-1:0]  state_o,
  output logic                       ale_o,
  output logic                       cycle_end_o,
  output logic [IDX_W-1:0]           mcycle_idx_o
);
  localparam int unsigned SW         = $clog2(STATES);
  localparam int unsigned CLKS_PER_MC = 2 * STATES;
  localparam int unsigned QUAL_CLKS  = QUAL_MCYC * CLKS_PER_MC;

  logic core_rst;

  mc_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (rst_pin_i),
    .core_rst_o (core_rst)
  );

  mc_phase_seq #(.STATES(STATES), .SW(SW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (core_rst),
    .phase_o   (phase_o),
    .state_o   (state_o),
    .ale_o     (ale_o),
    .cyc_end_o (cycle_end_o)
  );

  mc_cycle_idx #(.IDX_W(IDX_W)) u_idx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (core_rst),
    .cyc_end_i (cycle_end_o),
    .len_i     (inst_len_e'(inst_len_i)),
    .idx_o     (mcycle_idx_o)
  );

  assign core_rst_o = core_rst;

  a_r4_end_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_o |-> (phase_o && state_o == SW'(STATES - 1)));
  a_r4_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_o |=> !cycle_end_o);
  a_r3_ale_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> phase_o);
  a_r3_ale_width: assert property (@(posedge clk_i) disable iff (!rst_ni || core_rst)
    $rose(ale_o) |=> ale_o);
endmodule

// File: tb/tb_mc_timing_gen.sv
module tb_mc_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic [1:0] len = 2'b00;
  logic       core_rst, phase, ale, cend;
  logic [2:0] state;
  logic [1:0] idx;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  mc_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_i(pin), .inst_len_i(len),
    .core_rst_o(core_rst), .phase_o(phase), .state_o(state), .ale_o(ale),
    .cycle_end_o(cend), .mcycle_idx_o(idx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // n-th advance after release: compare every output with the position model
  task automatic chk_pos(input int n, input int cyc_len);
    int p = n % 12;
    chk("R2", "phase", phase, p % 2);
    chk("R2", "state", state, p / 2);
    chk("R3", "ale", ale, (p == 1 || p == 2 || p == 7 || p == 8) ? 1 : 0);
    chk("R4", "cycle_end", cend, (p == 11) ? 1 : 0);
    chk("R9", "mcycle_idx", idx, (n / 12) % cyc_len);
  endtask

  task automatic t_power_reset();
    tick();
    chk("R1", "core_rst", core_rst, 0);
    chk("R1", "phase", phase, 0);
    chk("R1", "state", state, 0);
    chk("R1", "ale", ale, 0);
    chk("R1", "cycle_end", cend, 0);
    chk("R1", "idx", idx, 0);
    rst_n = 1'b1;
  endtask

  // pin already high before edge 0
  task automatic t_qualify();
    for (int i = 0; i < 25; i++) tick();
    chk("R5", "core_rst after 25 edges", core_rst, 0);
    tick();
    chk("R5", "core_rst after 26 edges", core_rst, 1);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R7", "held state", state, 0);
      chk("R7", "held phase", phase, 0);
      chk("R7", "held ale", ale, 0);
      chk("R7", "held idx", idx, 0);
    end
  endtask

  task automatic t_release();
    pin = 1'b0;
    tick();
    tick();
    chk("R8", "core_rst after edge 1", core_rst, 1);
    tick();
    chk("R8", "core_rst after edge 2", core_rst, 0);
    chk("R8", "state at release", state, 0);
    tick();
    chk("R8", "phase after edge 3", phase, 1);
    chk("R8", "ale after edge 3", ale, 1);
  endtask

  task automatic core_reset();
    pin = 1'b1;
    for (int i = 0; i < 30; i++) tick();
    chk("R5", "core_rst asserted", core_rst, 1);
    pin = 1'b0;
    for (int i = 0; i < 3; i++) tick();
  endtask

  task automatic t_run(input logic [1:0] l, input int cyc_len, input int ncyc);
    len = l;
    core_reset();
    for (int n = 1; n <= 12 * ncyc; n++) begin
      tick();
      chk_pos(n, cyc_len);
    end
  endtask

  task automatic t_short_pulses();
    len = 2'b01;
    core_reset();
    for (int n = 1; n <= 60; n++) begin
      pin = ((n >= 1 && n <= 20) || (n >= 24 && n <= 43)) ? 1'b1 : 1'b0;
      tick();
      chk("R6", "core_rst stays low", core_rst, 0);
      chk_pos(n, 2);
    end
    pin = 1'b0;
  endtask

  initial begin
    #300000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_power_reset();
    t_qualify();
    t_release();
    t_run(2'b00, 1, 3);
    t_run(2'b01, 2, 5);
    t_run(2'b10, 4, 9);
    t_run(2'b11, 4, 5);
    t_short_pulses();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule